// File: doc/BRIEF.md
# Four-Phase Accumulator Processor

This block is a small sequential processor built around a single 16-bit accumulator. It has a 12-bit program counter and an instruction register. One shared word array holds both the program and its data. A phase generator steps every instruction through four fixed phases: fetch, decode, prepare and execute. In each phase a decoder raises a handful of named control strobes:

- the address-source select;
- the instruction-register load;
- the PC increment and the PC load;
- the ALU operation select;
- the accumulator load and the accumulator shift.

No microprogram is involved, and nothing is pipelined.

An instruction word carries a 4-bit opcode in bits 15:12 and a 12-bit memory address in bits 11:0. The instruction set has eight operations:

- add a memory word to the accumulator;
- load the accumulator from memory;
- store the accumulator to memory;
- clear the accumulator;
- shift the accumulator right by one;
- unconditional jump;
- jump when the accumulator is zero;
- halt.

A host port can write and read the array while the core is held in reset or has halted. This lets a test environment place a program and then inspect its results.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows PC = 0, accumulator = 0, phase = fetch (code 0) and halted = 0.
- R2: Out of reset and not halted, the phase output advances by one on each rising edge in the cycle fetch(0), decode(1), prepare(2), execute(3), fetch(0), so every instruction takes exactly four cycles.
- R3: The fetch phase latches the word at address PC into the instruction register. At the edge that ends the decode phase, PC increases by one.
- R4: Opcode 0x1 (add) leaves the accumulator equal to the old accumulator plus the word at the address field, modulo 2^16, at the end of the execute phase.
- R5: Opcode 0x2 (load) copies the addressed word into the accumulator. Opcode 0x7 (clear) sets the accumulator to zero.
- R6: Opcode 0x3 (store) writes the accumulator to the addressed word, only at the edge that ends the execute phase.
- R7: Opcode 0x4 (jump) sets PC to the address field at the edge that ends the prepare phase.
- R8: Opcode 0x5 (jump if zero) sets PC to the address field at the end of the prepare phase when the accumulator is zero. Otherwise PC keeps its incremented value.
- R9: Opcode 0x6 (shift) moves the accumulator one bit right, with a zero entering bit 15.
- R10: Opcode 0xF (halt) raises `halted` at the end of its execute phase. PC, the accumulator and the phase then stay fixed until reset.
- R11: Opcode 0x0 and every opcode without an assigned meaning change neither the accumulator nor memory. Such an instruction only advances the PC.
- R12: The accumulator changes only at the edge ending an execute phase. PC changes only at edges ending a decode or prepare phase.
- R13: A host write (`host_we`) takes effect only while `rst` is high or `halted` is set. It is ignored while the core runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe to the word array |
| host_addr | input | 12 | Host read/write address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Word at `host_addr`, combinational |
| halted | output | 1 | Core stopped by a halt instruction |
| phase_out | output | 2 | Current phase: 0 fetch, 1 decode, 2 prepare, 3 execute |
| pc_out | output | 12 | Program counter |
| acc_out | output | 16 | Accumulator |

## Verification
Two pairs of functions can meet at the same point in time.

The first pair is the conditional jump and the accumulator update. The conditional jump tests the accumulator in its prepare phase, only three cycles after the preceding instruction's execute phase wrote it. To provoke this, a jump-if-zero is placed directly after a clear and directly after a load of a nonzero word. Each case is judged by the PC value at which the program halts.

The second pair is a host write and the core's own memory traffic, which share the single write port. A host write is issued while the program runs. It is judged by reading the location back after the halt and finding its earlier content.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OP_W   = 4;
    localparam int ADDR_W = 12;
    localparam int WORD_W = OP_W + ADDR_W;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_PREP   = 2'd2,
        PH_EXEC   = 2'd3
    } phase_e;

    localparam logic [OP_W-1:0] OP_NOP = 4'h0;
    localparam logic [OP_W-1:0] OP_ADD = 4'h1;
    localparam logic [OP_W-1:0] OP_LDA = 4'h2;
    localparam logic [OP_W-1:0] OP_STA = 4'h3;
    localparam logic [OP_W-1:0] OP_JMP = 4'h4;
    localparam logic [OP_W-1:0] OP_JZ  = 4'h5;
    localparam logic [OP_W-1:0] OP_SHR = 4'h6;
    localparam logic [OP_W-1:0] OP_CLR = 4'h7;
    localparam logic [OP_W-1:0] OP_HLT = 4'hF;

    typedef enum logic [1:0] {
        ALU_HOLD = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_PASS = 2'd2,
        ALU_ZERO = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic    addr_sel_ir;
        logic    ir_ld;
        logic    pc_inc;
        logic    pc_ld;
        alu_op_e alu_op;
        logic    acc_ld;
        logic    acc_shr;
        logic    mem_we;
        logic    halt;
    } ctrl_t;

    function automatic logic [OP_W-1:0] op_field(input logic [WORD_W-1:0] w);
        return w[WORD_W-1 -: OP_W];
    endfunction

    function automatic logic [ADDR_W-1:0] addr_field(input logic [WORD_W-1:0] w);
        return w[ADDR_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] make_instr(input logic [OP_W-1:0] op,
                                                     input logic [ADDR_W-1:0] a);
        return {op, a};
    endfunction

endpackage

// File: rtl/acc_phase_gen.sv
module acc_phase_gen
    import acc_cpu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   halt_req,
    output phase_e phase,
    output logic   halted
);

    phase_e phase_nxt;

    always_comb begin
        case (phase)
            PH_FETCH:  phase_nxt = PH_DECODE;
            PH_DECODE: phase_nxt = PH_PREP;
            PH_PREP:   phase_nxt = PH_EXEC;
            default:   phase_nxt = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_FETCH;
            halted <= 1'b0;
        end else if (!halted) begin
            phase <= phase_nxt;
            if (phase == PH_EXEC && halt_req) begin
                halted <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/acc_ctrl_dec.sv
module acc_ctrl_dec
    import acc_cpu_pkg::*;
(
    input  phase_e          phase,
    input  logic            halted,
    input  logic [OP_W-1:0] opcode,
    input  logic            acc_zero,
    output ctrl_t           ctrl
);

    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_HOLD;
        if (!halted) begin
            case (phase)
                PH_FETCH: begin
                    ctrl.ir_ld = 1'b1;
                end
                PH_DECODE: begin
                    ctrl.addr_sel_ir = 1'b1;
                    ctrl.pc_inc      = 1'b1;
                end
                PH_PREP: begin
                    ctrl.addr_sel_ir = 1'b1;
                    case (opcode)
                        OP_ADD:  ctrl.alu_op = ALU_ADD;
                        OP_LDA:  ctrl.alu_op = ALU_PASS;
                        OP_CLR:  ctrl.alu_op = ALU_ZERO;
                        OP_JMP:  ctrl.pc_ld  = 1'b1;
                        OP_JZ:   ctrl.pc_ld  = acc_zero;
                        default: ctrl.alu_op = ALU_HOLD;
                    endcase
                end
                default: begin
                    ctrl.addr_sel_ir = 1'b1;
                    case (opcode)
                        OP_ADD: begin
                            ctrl.alu_op = ALU_ADD;
                            ctrl.acc_ld = 1'b1;
                        end
                        OP_LDA: begin
                            ctrl.alu_op = ALU_PASS;
                            ctrl.acc_ld = 1'b1;
                        end
                        OP_CLR: begin
                            ctrl.alu_op = ALU_ZERO;
                            ctrl.acc_ld = 1'b1;
                        end
                        OP_STA:  ctrl.mem_we  = 1'b1;
                        OP_SHR:  ctrl.acc_shr = 1'b1;
                        OP_HLT:  ctrl.halt    = 1'b1;
                        default: ctrl.alu_op  = ALU_HOLD;
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_cpu_pkg::*;
(
    input  alu_op_e           op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] y
);

    always_comb begin
        case (op)
            ALU_ADD:  y = a + b;
            ALU_PASS: y = b;
            ALU_ZERO: y = '0;
            default:  y = a;
        endcase
    end

endmodule

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata_a = store[raddr_a];
    assign rdata_b = store[raddr_b];

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              halted,
    output logic [1:0]        phase_out,
    output logic [ADDR_W-1:0] pc_out,
    output logic [WORD_W-1:0] acc_out
);

    phase_e            phase;
    ctrl_t             ctrl;
    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] ir;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] alu_y;
    logic [WORD_W-1:0] mem_q;
    logic [ADDR_W-1:0] core_addr;
    logic              core_we;
    logic              host_ok;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata;

    acc_phase_gen u_phase (
        .clk      (clk),
        .rst      (rst),
        .halt_req (ctrl.halt),
        .phase    (phase),
        .halted   (halted)
    );

    acc_ctrl_dec u_dec (
        .phase    (phase),
        .halted   (halted),
        .opcode   (op_field(ir)),
        .acc_zero (acc == '0),
        .ctrl     (ctrl)
    );

    acc_alu u_alu (
        .op (ctrl.alu_op),
        .a  (acc),
        .b  (mem_q),
        .y  (alu_y)
    );

    assign core_addr = ctrl.addr_sel_ir ? addr_field(ir) : pc;
    assign core_we   = ctrl.mem_we;
    assign host_ok   = rst | halted;
    assign mem_we    = core_we | (host_ok & host_we);
    assign mem_waddr = core_we ? core_addr : host_addr;
    assign mem_wdata = core_we ? acc : host_wdata;

    acc_mem #(
        .AW (ADDR_W),
        .DW (WORD_W)
    ) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (core_addr),
        .rdata_a (mem_q),
        .raddr_b (host_addr),
        .rdata_b (host_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            ir  <= '0;
            acc <= '0;
        end else begin
            if (ctrl.ir_ld) begin
                ir <= mem_q;
            end
            if (ctrl.pc_ld) begin
                pc <= addr_field(ir);
            end else if (ctrl.pc_inc) begin
                pc <= pc + 1'b1;
            end
            if (ctrl.acc_ld) begin
                acc <= alu_y;
            end else if (ctrl.acc_shr) begin
                acc <= {1'b0, acc[WORD_W-1:1]};
            end
        end
    end

    assign phase_out = phase;
    assign pc_out    = pc;
    assign acc_out   = acc;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              halted,
    input logic [1:0]        phase_out,
    input logic [ADDR_W-1:0] pc_out,
    input logic [WORD_W-1:0] acc_out,
    input logic [WORD_W-1:0] ir,
    input logic              core_we
);

    logic rst_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    always @(posedge clk) begin
        if (rst_q) begin
            assert_reset_state_R1: assert (pc_out == '0 && acc_out == '0 &&
                                           phase_out == 2'd0 && !halted)
                else $error("reset state wrong");
        end
    end

    assert_phase_order_R2: assert property (@(posedge clk) disable iff (rst)
        !halted |=> phase_out == $past(phase_out) + 2'd1);

    assert_pc_increment_R3: assert property (@(posedge clk) disable iff (rst)
        (!halted && phase_out == 2'd1) |=> pc_out == $past(pc_out) + 1'b1);

    assert_store_in_exec_R6: assert property (@(posedge clk) disable iff (rst)
        core_we |-> (phase_out == 2'd3 && !halted));

    assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
        (!halted && phase_out == 2'd2 && ir[WORD_W-1 -: OP_W] == OP_JMP)
        |=> pc_out == $past(ir[ADDR_W-1:0]));

    assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc_out) && $stable(acc_out) && $stable(phase_out)));

    assert_acc_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (phase_out != 2'd3) |=> $stable(acc_out));

    assert_pc_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (!halted && (phase_out == 2'd0 || phase_out == 2'd3)) |=> $stable(pc_out));

endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .halted    (halted),
    .phase_out (phase_out),
    .pc_out    (pc_out),
    .acc_out   (acc_out),
    .ir        (ir),
    .core_we   (core_we)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
    import acc_cpu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [WORD_W-1:0] host_wdata = '0;
    logic [WORD_W-1:0] host_rdata;
    logic              halted;
    logic [1:0]        phase_out;
    logic [ADDR_W-1:0] pc_out;
    logic [WORD_W-1:0] acc_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    acc_cpu u_dut (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .halted     (halted),
        .phase_out  (phase_out),
        .pc_out     (pc_out),
        .acc_out    (acc_out)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic poke(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic peek(input logic [ADDR_W-1:0] a, output logic [WORD_W-1:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic run_to_halt();
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (halted) break;
        end
    endtask

    task automatic t_arith();
        logic [WORD_W-1:0] d;
        hold_reset();
        poke(12'h000, make_instr(OP_LDA, 12'h040));
        poke(12'h001, make_instr(OP_ADD, 12'h041));
        poke(12'h002, make_instr(OP_STA, 12'h042));
        poke(12'h003, make_instr(OP_SHR, 12'h000));
        poke(12'h004, make_instr(OP_STA, 12'h043));
        poke(12'h005, make_instr(OP_HLT, 12'h000));
        poke(12'h040, 16'h1234);
        poke(12'h041, 16'h0F0F);
        run_to_halt();
        check("R10 halted", halted, 1);
        peek(12'h042, d);
        check("R4 add+store", d, 16'h2143);
        peek(12'h043, d);
        check("R9 shift", d, 16'h10A1);
        check("R5 acc after shift", acc_out, 16'h10A1);
        check("R10 pc after halt", pc_out, 12'h006);
    endtask

    task automatic t_wrap_shift();
        logic [WORD_W-1:0] d;
        hold_reset();
        poke(12'h000, make_instr(OP_LDA, 12'h050));
        poke(12'h001, make_instr(OP_ADD, 12'h051));
        poke(12'h002, make_instr(OP_STA, 12'h052));
        poke(12'h003, make_instr(OP_LDA, 12'h053));
        poke(12'h004, make_instr(OP_SHR, 12'h000));
        poke(12'h005, make_instr(OP_HLT, 12'h000));
        poke(12'h050, 16'hFFFF);
        poke(12'h051, 16'h0002);
        poke(12'h053, 16'h8001);
        run_to_halt();
        peek(12'h052, d);
        check("R4 add wraps", d, 16'h0001);
        check("R9 zero into msb", acc_out, 16'h4000);
    endtask

    task automatic t_timing();
        hold_reset();
        poke(12'h000, make_instr(OP_JMP, 12'h010));
        poke(12'h010, make_instr(OP_HLT, 12'h000));
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 phase decode", phase_out, 2'd1);
        check("R3 pc held in fetch", pc_out, 12'h000);
        @(negedge clk);
        check("R2 phase prepare", phase_out, 2'd2);
        check("R3 pc incremented", pc_out, 12'h001);
        @(negedge clk);
        check("R2 phase execute", phase_out, 2'd3);
        check("R7 jump at prepare", pc_out, 12'h010);
        @(negedge clk);
        check("R2 phase wraps to fetch", phase_out, 2'd0);
        check("R12 pc stable over execute", pc_out, 12'h010);
        check("R12 acc untouched", acc_out, 16'h0000);
        repeat (3) @(negedge clk);
        check("R10 not halted before exec end", halted, 0);
        @(negedge clk);
        check("R10 halted after 8 cycles", halted, 1);
        check("R10 pc at halt", pc_out, 12'h011);
    endtask

    task automatic t_jz();
        logic [WORD_W-1:0] d;
        hold_reset();
        poke(12'h000, make_instr(OP_CLR, 12'h000));
        poke(12'h001, make_instr(OP_JZ,  12'h008));
        poke(12'h002, make_instr(OP_HLT, 12'h000));
        poke(12'h008, make_instr(OP_LDA, 12'h030));
        poke(12'h009, make_instr(OP_JZ,  12'h00C));
        poke(12'h00A, make_instr(OP_STA, 12'h031));
        poke(12'h00B, make_instr(OP_HLT, 12'h000));
        poke(12'h00C, make_instr(OP_HLT, 12'h000));
        poke(12'h030, 16'h0005);
        poke(12'h031, 16'h0000);
        run_to_halt();
        check("R8 taken then not taken pc", pc_out, 12'h00C);
        peek(12'h031, d);
        check("R8 fall-through store", d, 16'h0005);
    endtask

    task automatic t_undef();
        logic [WORD_W-1:0] d;
        hold_reset();
        poke(12'h000, make_instr(OP_LDA, 12'h060));
        poke(12'h001, make_instr(4'h8,   12'h061));
        poke(12'h002, make_instr(OP_NOP, 12'h061));
        poke(12'h003, make_instr(4'hC,   12'h061));
        poke(12'h004, make_instr(OP_HLT, 12'h000));
        poke(12'h060, 16'hA5A5);
        poke(12'h061, 16'h0777);
        poke(12'h070, 16'h1111);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        host_addr  = 12'h070;
        host_wdata = 16'hDEAD;
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (halted) break;
        end
        check("R11 acc kept", acc_out, 16'hA5A5);
        check("R11 pc advanced", pc_out, 12'h005);
        peek(12'h061, d);
        check("R11 memory kept", d, 16'h0777);
        peek(12'h070, d);
        check("R13 host write ignored while running", d, 16'h1111);
        poke(12'h070, 16'h2222);
        peek(12'h070, d);
        check("R13 host write while halted", d, 16'h2222);
    endtask

    task automatic t_freeze_reset();
        logic [ADDR_W-1:0] p;
        logic [WORD_W-1:0] a;
        p = pc_out;
        a = acc_out;
        repeat (20) @(negedge clk);
        check("R10 still halted", halted, 1);
        check("R10 pc frozen", pc_out, p);
        check("R10 acc frozen", acc_out, a);
        check("R10 phase frozen", phase_out, 2'd0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 pc cleared", pc_out, 12'h000);
        check("R1 acc cleared", acc_out, 16'h0000);
        check("R1 phase fetch", phase_out, 2'd0);
        check("R1 halted cleared", halted, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R1 initial pc", pc_out, 12'h000);
        check("R1 initial acc", acc_out, 16'h0000);
        t_arith();
        t_wrap_shift();
        t_timing();
        t_jz();
        t_undef();
        t_freeze_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule